// File: doc/BRIEF.md
# Dual-Register DDS Waveform Core

This block is a numerically controlled oscillator clocked by the master clock. It keeps two frequency tuning words and two phase offset words. On each clock it adds the chosen tuning word to a 28-bit phase accumulator. It then adds the chosen 12-bit phase offset to the top 12 accumulator bits. The resulting 12-bit phase is mapped to a 10-bit sample, either a sine built from a quarter-wave table or a triangle ramp. The output frequency is f_clk × word / 2^28. For example, word 0x2492492 gives one seventh of the clock rate.

Either external select pins or control-register bits choose which word and which offset are in use. Switching between the pair at run time gives frequency-shift and phase-shift keying. The synchronous reset clears only the accumulator and the pipeline, so the programmed words survive it. A sleep pin or a sleep bit holds the sample at midscale and marks it invalid. A one-bit sign output can carry either the phase MSB or an external comparator level. When disabled, it is held low. All registers are loaded through a parallel write port.

Top module: `dds_core`

## Requirements
- R1: While `rst` is high, and on the first edge it is seen high, the accumulator, the select samplers and the pipeline are cleared. After that edge `sample_o` is 512, `sample_valid_o` is 0 and `sign_o` is 0.
- R2: A write with `wr_en` high lands on the next clock edge. The address map is: 0 is frequency word 0 (28 bits), 1 is frequency word 1, 2 is phase offset 0 (low 12 bits of `wr_data`), 3 is phase offset 1, and 4 is the control word. Addresses 5 to 7 change nothing. Reset never alters these registers, and all of them power up to zero.
- R3: On every clock out of reset, the accumulator adds the selected frequency word modulo 2^28.
- R4: Control bit 0 (internal select) set: control bit 1 picks the frequency word. Bit 0 clear: `fsel_i` picks it, after being sampled on a rising clock edge. In both cases, value 1 selects word 1.
- R5: Phase offset selection follows the same rule, using control bit 2 or the sampled `psel_i`. The phase is the top 12 accumulator bits plus the selected offset, modulo 4096, registered one edge after the accumulator.
- R6: With control bit 3 clear, the sample is a sine. Let p be the 12-bit phase and i = p[9:0], inverted when p[10] is set. Let q = floor(511.5 × sin(π(i+0.5)/2048)). The sample is 512+q when p[11]=0 and 511−q otherwise. It appears two edges after the phase register.
- R7: With control bit 3 set, the sample is a triangle: p[10:1], inverted when p[11] is set. It has the same two-edge latency as the sine.
- R8: While `sleep_i` or control bit 4 is high at an edge, that edge loads `sample_o` with 512 and `sample_valid_o` with 0. Otherwise `sample_valid_o` is 1.
- R9: Control bit 5 enables `sign_o`. Control bit 6 set routes phase bit 11 through it, and clear routes `cmp_i`. When bit 5 is clear, `sign_o` is 0. `sign_o` is registered one edge after the phase register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high clear of accumulator and pipeline |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 28 | Register write data |
| fsel_i | input | 1 | Frequency word select pin |
| psel_i | input | 1 | Phase offset select pin |
| sleep_i | input | 1 | Sleep pin, holds sample at midscale |
| cmp_i | input | 1 | Digital comparator level |
| sample_o | output | 10 | Waveform sample |
| sample_valid_o | output | 1 | Sample valid (low in reset and sleep) |
| sign_o | output | 1 | Sign-bit output |

## Verification
The bench switches the word and offset selects both from the pins and from the control bits in the middle of a run. A core that ignores the source bit, or that does not sample the pins, would drift in phase at once and mismatch the reference model. A reset in the middle of a run is followed by more output with no rewrite. A core that cleared its registers on reset would then fall to a flat midscale. A tuning word of all ones checks wrap-around. Triangle mode, the sleep pin and sleep bit, every sign routing, and a write to an unused address are each compared on every clock. A wrong mirror in the quarter-wave table, a stuck valid, or a sign mux taken from the wrong source would show as a sample or sign mismatch.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int CTRL_W = 7;

  // bit 0 is the LSB (sel_internal), bit 6 the MSB (sign_nco)
  typedef struct packed {
    logic sign_nco;
    logic sign_en;
    logic sleep;
    logic tri_mode;
    logic phase_bit;
    logic freq_bit;
    logic sel_internal;
  } dds_ctrl_t;

  typedef enum logic [2:0] {
    ADDR_FREQ0  = 3'd0,
    ADDR_FREQ1  = 3'd1,
    ADDR_PHASE0 = 3'd2,
    ADDR_PHASE1 = 3'd3,
    ADDR_CTRL   = 3'd4
  } dds_addr_e;
endpackage

// File: rtl/dds_regfile.sv
module dds_regfile
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int NREG  = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_addr,
  input  logic [ACC_W-1:0]           wr_data,
  output logic [NREG-1:0][ACC_W-1:0] freq_o,
  output logic [NREG-1:0][PH_W-1:0]  phase_o,
  output dds_ctrl_t                  ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q = '0;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_regs
    logic [ACC_W-1:0] fq = '0;
    logic [PH_W-1:0]  pq = '0;
    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == 3'(ADDR_FREQ0) + 3'(gi))  fq <= wr_data;
      if (wr_en && wr_addr == 3'(ADDR_PHASE0) + 3'(gi)) pq <= wr_data[PH_W-1:0];
    end
    assign freq_o[gi]  = fq;
    assign phase_o[gi] = pq;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr == 3'(ADDR_CTRL)) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign ctrl_o = dds_ctrl_t'(ctrl_q);

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(freq_o) && $stable(phase_o) && $stable(ctrl_q)); // R2
  AST_FREQ0_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'(ADDR_FREQ0)) |=> freq_o[0] == $past(wr_data)); // R2
endmodule

// File: rtl/dds_phase.sv
module dds_phase
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0][ACC_W-1:0]   freq_i,
  input  logic [1:0][PH_W-1:0]    offs_i,
  input  dds_ctrl_t               ctrl_i,
  input  logic                    fsel_pin_i,
  input  logic                    psel_pin_i,
  output logic [PH_W-1:0]         phase_o,
  output logic                    tri_o
);
  logic             fsel_q, psel_q;
  logic             fsel, psel;
  logic [ACC_W-1:0] acc_q;

  assign fsel = ctrl_i.sel_internal ? ctrl_i.freq_bit  : fsel_q;
  assign psel = ctrl_i.sel_internal ? ctrl_i.phase_bit : psel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_q  <= 1'b0;
      psel_q  <= 1'b0;
      acc_q   <= '0;
      phase_o <= '0;
      tri_o   <= 1'b0;
    end else begin
      fsel_q  <= fsel_pin_i;
      psel_q  <= psel_pin_i;
      acc_q   <= acc_q + freq_i[fsel];
      phase_o <= acc_q[ACC_W-1 -: PH_W] + offs_i[psel];
      tri_o   <= ctrl_i.tri_mode;
    end
  end

  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc_q == '0 && phase_o == '0)); // R1
endmodule

// File: rtl/dds_wave.sv
module dds_wave #(
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             tri_i,
  input  logic             sleep_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int  QA     = PH_W - 2;
  localparam int  QDEPTH = 2 ** QA;
  localparam int  AMP_W  = OUT_W - 1;
  localparam int  MID    = 2 ** (OUT_W - 1);
  localparam real PI     = 3.141592653589793;
  localparam logic [OUT_W-1:0] MID_V = OUT_W'(MID);

  function automatic logic [AMP_W-1:0] quarter_val(input int i);
    real ang;
    ang = PI * (real'(i) + 0.5) / real'(2 ** (PH_W - 1));
    return AMP_W'($rtoi((real'(MID) - 0.5) * $sin(ang)));
  endfunction

  logic [AMP_W-1:0] rom [QDEPTH];
  for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_rom
    localparam logic [AMP_W-1:0] QV = quarter_val(gi);
    assign rom[gi] = QV;
  end

  logic [QA-1:0]    idx;
  logic [AMP_W-1:0] rom_q;
  logic [OUT_W-1:0] ramp_q;
  logic             neg_q, mode_q;

  assign idx = phase_i[PH_W-2] ? ~phase_i[QA-1:0] : phase_i[QA-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_q  <= '0;
      ramp_q <= '0;
      neg_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      rom_q  <= rom[idx];
      ramp_q <= phase_i[PH_W-1] ? ~phase_i[PH_W-2 -: OUT_W] : phase_i[PH_W-2 -: OUT_W];
      neg_q  <= phase_i[PH_W-1];
      mode_q <= tri_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= MID_V;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= ~sleep_i;
      if (sleep_i)     sample_o <= MID_V;
      else if (mode_q) sample_o <= ramp_q;
      else if (neg_q)  sample_o <= MID_V - OUT_W'(1) - OUT_W'(rom_q);
      else             sample_o <= MID_V + OUT_W'(rom_q);
    end
  end

  AST_SINE_UPPER_HALF: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !neg_q) |=> (sample_o >= MID_V || !valid_o)); // R6
  AST_SLEEP_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> sample_o == MID_V); // R8
endmodule

// File: rtl/dds_core.sv
module dds_core
  import dds_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             fsel_i,
  input  logic             psel_i,
  input  logic             sleep_i,
  input  logic             cmp_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             sample_valid_o,
  output logic             sign_o
);
  logic [1:0][ACC_W-1:0] freq;
  logic [1:0][PH_W-1:0]  offs;
  dds_ctrl_t             ctrl;
  logic [PH_W-1:0]       phase;
  logic                  tri_mode;

  dds_regfile #(.ACC_W(ACC_W), .PH_W(PH_W), .NREG(2)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freq_o(freq), .phase_o(offs), .ctrl_o(ctrl)
  );

  dds_phase #(.ACC_W(ACC_W), .PH_W(PH_W)) i_phase (
    .clk(clk), .rst(rst), .freq_i(freq), .offs_i(offs), .ctrl_i(ctrl),
    .fsel_pin_i(fsel_i), .psel_pin_i(psel_i), .phase_o(phase), .tri_o(tri_mode)
  );

  dds_wave #(.PH_W(PH_W), .OUT_W(OUT_W)) i_wave (
    .clk(clk), .rst(rst), .phase_i(phase), .tri_i(tri_mode),
    .sleep_i(sleep_i | ctrl.sleep), .sample_o(sample_o), .valid_o(sample_valid_o)
  );

  always_ff @(posedge clk) begin
    if (rst) sign_o <= 1'b0;
    else     sign_o <= ctrl.sign_en & (ctrl.sign_nco ? phase[PH_W-1] : cmp_i);
  end

  AST_SIGN_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    !ctrl.sign_en |=> !sign_o); // R9
  AST_SIGN_FROM_CMP: assert property (@(posedge clk) disable iff (rst)
    (ctrl.sign_en && !ctrl.sign_nco) |=> sign_o == $past(cmp_i)); // R9
endmodule

// File: tb/test_dds_core.sv
module test_dds_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [27:0] wr_data = '0;
  logic        fsel_i = 1'b0, psel_i = 1'b0, sleep_i = 1'b0, cmp_i = 1'b0;
  logic [9:0]  sample_o;
  logic        sample_valid_o, sign_o;

  int    n_checks = 0, n_fail = 0, cycles = 0;
  bit    started = 0, done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  dds_core i_dds_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsel_i(fsel_i), .psel_i(psel_i), .sleep_i(sleep_i), .cmp_i(cmp_i),
    .sample_o(sample_o), .sample_valid_o(sample_valid_o), .sign_o(sign_o)
  );

  // behavioural reference model
  int m_freq[2] = '{0, 0};
  int m_off[2]  = '{0, 0};
  int m_ctrl = 0, m_acc = 0, m_fsq = 0, m_psq = 0;
  int ph_pipe[$];
  int mode_pipe[$];
  int exp_sample = 512, exp_valid = 0, exp_sign = 0;

  function automatic int wave(int p, int tri_m);
    int t, idx, q;
    if (tri_m != 0) begin
      t = (p >> 1) & 1023;
      return ((p >> 11) & 1) ? 1023 - t : t;
    end
    idx = p & 1023;
    if ((p >> 10) & 1) idx = 1023 - idx;
    q = $rtoi(511.5 * $sin(3.141592653589793 * (real'(idx) + 0.5) / 2048.0));
    return ((p >> 11) & 1) ? 511 - q : 512 + q;
  endfunction

  always @(posedge clk) begin
    int fs, ps, ph_r, s3p, s3m, cmp_now;
    cycles++;
    started = 1;
    cmp_now = cmp_i;
    if (rst) begin
      m_acc = 0; m_fsq = 0; m_psq = 0;
      ph_pipe = '{0, 0}; mode_pipe = '{0, 0};
      exp_sample = 512; exp_valid = 0; exp_sign = 0;
    end else begin
      s3p = ph_pipe[0]; s3m = mode_pipe[0];
      ph_r = ph_pipe[1];
      if (sleep_i || ((m_ctrl >> 4) & 1)) begin
        exp_sample = 512; exp_valid = 0;
      end else begin
        exp_sample = wave(s3p, s3m); exp_valid = 1;
      end
      if ((m_ctrl >> 5) & 1) exp_sign = ((m_ctrl >> 6) & 1) ? ((ph_r >> 11) & 1) : cmp_now;
      else exp_sign = 0;
      fs = (m_ctrl & 1) ? ((m_ctrl >> 1) & 1) : m_fsq;
      ps = (m_ctrl & 1) ? ((m_ctrl >> 2) & 1) : m_psq;
      void'(ph_pipe.pop_front()); void'(mode_pipe.pop_front());
      ph_pipe.push_back(((m_acc >> 16) + m_off[ps]) & 12'hFFF);
      mode_pipe.push_back((m_ctrl >> 3) & 1);
      m_acc = (m_acc + m_freq[fs]) & 28'hFFFFFFF;
      m_fsq = fsel_i; m_psq = psel_i;
    end
    if (wr_en) begin
      case (wr_addr)
        3'd0: m_freq[0] = int'(wr_data);
        3'd1: m_freq[1] = int'(wr_data);
        3'd2: m_off[0]  = int'(wr_data) & 12'hFFF;
        3'd3: m_off[1]  = int'(wr_data) & 12'hFFF;
        3'd4: m_ctrl    = int'(wr_data) & 7'h7F;
        default: ;
      endcase
    end
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check(cur_req, "sample", int'(sample_o), exp_sample);
      check(cur_req, "valid", int'(sample_valid_o), exp_valid);
      check(cur_req, "sign", int'(sign_o), exp_sign);
    end
  end

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 28'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    run(3);
    check("R1", "reset sample", int'(sample_o), 512);
    check("R1", "reset valid", int'(sample_valid_o), 0);
    check("R1", "reset sign", int'(sign_o), 0);
    // R2: program registers
    cur_req = "R2";
    wr(0, 28'h0100000);
    wr(1, 28'h2492492);
    wr(2, 0);
    wr(3, 12'h400);
    wr(4, 7'h00);
    rst = 1'b0;
    // R6: sine from word 0, pin selects low
    cur_req = "R6";
    run(300);
    // R4: pin frequency select
    cur_req = "R4";
    fsel_i = 1'b1; run(20);
    fsel_i = 1'b0; run(7);
    fsel_i = 1'b1; run(13);
    // R5: pin phase select
    cur_req = "R5";
    psel_i = 1'b1; run(15);
    psel_i = 1'b0; run(5);
    // R4: internal bits override pins
    cur_req = "R4";
    wr(4, 7'b0000011); run(20);
    fsel_i = 1'b0; run(5);
    wr(4, 7'b0000001); run(10);
    cur_req = "R5";
    wr(4, 7'b0000101); run(12);
    psel_i = 1'b1; wr(4, 7'b0000001); run(10);
    // R2: reset mid-run keeps words; unused address ignored
    cur_req = "R2";
    wr(4, 7'b0000000);
    rst = 1'b1; run(2); rst = 1'b0; run(30);
    wr(5, 28'hFFFFFFF); run(30);
    // R3: wrap-around with all-ones word
    cur_req = "R3";
    wr(0, 28'hFFFFFFF); fsel_i = 1'b0; psel_i = 1'b0; run(40);
    wr(0, 28'h0300000); run(20);
    // R7: triangle
    cur_req = "R7";
    wr(4, 7'b0001000); run(300);
    // R8: sleep by pin and by bit
    cur_req = "R8";
    sleep_i = 1'b1; run(8);
    check("R8", "sleep sample", int'(sample_o), 512);
    sleep_i = 1'b0; run(5);
    wr(4, 7'b0010000); run(8);
    wr(4, 7'b0000000); run(5);
    // R9: sign output routings
    cur_req = "R9";
    wr(4, 7'b1100000); run(100);
    wr(4, 7'b0100000);
    for (int k = 0; k < 20; k++) begin
      cmp_i = k[0] ^ k[2];
      run(1);
    end
    wr(4, 7'b1000000); cmp_i = 1'b1; run(10);
    check("R9", "disabled sign", int'(sign_o), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule